// File: doc/BRIEF.md
# Periodic-correction seconds divider

This block divides a 32,768 Hz oscillator, presented as a one-clock enable on a faster system clock, down to a one-second tick and a minute index. It trims the long-term rate digitally rather than by changing a divide ratio. The trim works at the divide-by-256 stage. A positive trim drops one whole 256-cycle stage period from a chosen second. A negative trim stretches one stage period of that second by half a period (128 cycles). Either way the following stages always see a whole number of stage periods.

The trim follows a 64-minute cycle. With a 5-bit magnitude N, the first 2×N minutes of the cycle each have exactly one corrected second, which is the first second of the minute. All other seconds are nominal. The magnitude and sign are taken in only at the start of each 64-minute cycle. A software change therefore never splits a cycle. A square wave at 1/64 of the oscillator rate (512 Hz nominal) is brought out for rate measurement. It comes from the uncorrected count, so the trim never disturbs it.

All stage sizes are parameters. The defaults give the real rates, and a bench can shrink them to keep runs short.

Top module: `rate_trim_divider`

## Requirements
- R1: After reset, `sec_tick`, `minute` and `test_wave` are 0, the held trim is zero, and the first second is exactly 2^(PRE_W+SUB_W) enables long.
- R2: While the held magnitude is 0, every second lasts exactly 2^(PRE_W+SUB_W) `osc_en` pulses (32,768 at default parameters).
- R3: With held sign 1 (`trim_pos`=1, clock gains) and held magnitude N, second 0 of each minute m < 2N is shortened by 2^PRE_W pulses (256 at default parameters).
- R4: With held sign 0 (clock loses) and held magnitude N, second 0 of each minute m < 2N is lengthened by 2^(PRE_W-1) pulses (128 at default parameters).
- R5: Seconds other than second 0, and every second of minutes m ≥ 2N, are nominal. With N = 31, minutes 62 and 63 are never corrected.
- R6: `minute` increments by one on the tick that closes the last of SEC_PER_MIN seconds, wraps from 2^MIN_W−1 to 0, and changes at no other time.
- R7: `trim_mag` and `trim_pos` are sampled only on the tick that closes the last second of minute 2^MIN_W−1. Changes at any other time have no effect until that tick.
- R8: `test_wave` toggles after every 2^(PRE_W-3) `osc_en` pulses and holds otherwise, whatever the trim value.
- R9: With `osc_en` low nothing advances. `sec_tick` rises only in the clock after an edge where `osc_en` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| trim_mag | input | MAG_W | Trim magnitude N (0 to 31 by default) |
| trim_pos | input | 1 | Trim sign: 1 shortens seconds, 0 lengthens them |
| sec_tick | output | 1 | One-clock pulse at the end of each corrected second |
| minute | output | MIN_W | Minute index within the correction cycle |
| test_wave | output | 1 | Untrimmed square wave, period 2^(PRE_W-2) enables |

## Verification
`sec_tick` and the new `minute` value are registered. Both appear one clock after the edge that takes in the `osc_en` pulse closing a second. `test_wave` changes on the same edge that takes in its pulse. The bench drives inputs and samples outputs on the falling edge. At each falling edge it first credits the enable it drove for the edge just past, and only then compares. Each second's length is therefore measured in enables, not clocks. The bench also keeps its own copy of the trim value that should be held, latching it at the cycle-closing tick. This lets it tell exactly which second of which minute must be short, long or nominal.

// File: rtl/rate_trim_divider.sv
module rate_trim_divider #(
  parameter int PRE_W       = 8,
  parameter int SUB_W       = 7,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_W       = 6,
  parameter int MAG_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic [MAG_W-1:0] trim_mag,
  input  logic             trim_pos,
  output logic             sec_tick,
  output logic [MIN_W-1:0] minute,
  output logic             test_wave
);
  localparam int STAGE = 1 << PRE_W;
  localparam int HALF  = STAGE / 2;
  localparam int P1W   = PRE_W + 1;
  localparam int NOM   = 1 << (PRE_W + SUB_W);
  localparam int SECW  = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int CMPW  = (MIN_W > MAG_W + 1) ? MIN_W : MAG_W + 1;
  localparam int CHKW  = PRE_W + SUB_W + 2;

  logic [P1W-1:0]   p1;
  logic [SUB_W-1:0] p2;
  logic [SECW-1:0]  sec_idx;
  logic [MAG_W-1:0] lat_mag;
  logic             lat_pos;

  logic             corr_sec, stretch, skip, p1_wrap, sec_end, min_end, cyc_end;
  logic [P1W-1:0]   p1_lim;

  assign corr_sec = (sec_idx == '0) && (CMPW'(minute) < CMPW'({lat_mag, 1'b0}));
  assign stretch  = corr_sec && !lat_pos && (p2 == '0);
  assign skip     = corr_sec &&  lat_pos && (p2 == '0);
  assign p1_lim   = stretch ? P1W'(STAGE + HALF - 1) : P1W'(STAGE - 1);
  assign p1_wrap  = osc_en && (p1 == p1_lim);
  assign sec_end  = p1_wrap && (&p2);
  assign min_end  = sec_end && (sec_idx == SECW'(SEC_PER_MIN - 1));
  assign cyc_end  = min_end && (&minute);
  assign test_wave = p1[PRE_W-3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1       <= '0;
      p2       <= '0;
      sec_idx  <= '0;
      minute   <= '0;
      lat_mag  <= '0;
      lat_pos  <= 1'b0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= sec_end;
      if (osc_en) p1 <= p1_wrap ? '0 : p1 + 1'b1;
      if (p1_wrap) p2 <= p2 + SUB_W'(skip ? 2 : 1);
      if (sec_end) sec_idx <= min_end ? '0 : sec_idx + 1'b1;
      if (min_end) minute <= minute + 1'b1;
      if (cyc_end) begin
        lat_mag <= trim_mag;
        lat_pos <= trim_pos;
      end
    end
  end

  logic [CHKW-1:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)        chk_cnt <= '0;
    else if (sec_tick) chk_cnt <= CHKW'(osc_en);
    else               chk_cnt <= chk_cnt + CHKW'(osc_en);
  end

  AST_NOMINAL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && lat_mag == '0) |-> chk_cnt == CHKW'(NOM)); // R2
  AST_PERIOD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (chk_cnt == CHKW'(NOM) || chk_cnt == CHKW'(NOM - STAGE) || chk_cnt == CHKW'(NOM + HALF))); // R5
  AST_SHORT_IF_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && chk_cnt == CHKW'(NOM - STAGE)) |-> lat_pos); // R3
  AST_LONG_IF_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && chk_cnt == CHKW'(NOM + HALF)) |-> !lat_pos); // R4
  AST_TICK_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(osc_en)); // R9
  AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> $stable(test_wave)); // R8
  AST_MINUTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(minute) |-> sec_tick); // R6
  AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lat_mag) || !$stable(lat_pos)) |-> (sec_tick && minute == '0)); // R7
endmodule

// File: tb/rate_trim_divider_test.sv
`timescale 1ns/1ps
module rate_trim_divider_test;
  localparam int PRE_W = 4, SUB_W = 2, SPM = 2, MIN_W = 6, MAG_W = 5;
  localparam int STAGE = 1 << PRE_W;
  localparam int HALF  = STAGE / 2;
  localparam int NOM   = 1 << (PRE_W + SUB_W);
  localparam int NMIN  = 1 << MIN_W;

  logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, trim_pos = 1'b0;
  logic [MAG_W-1:0] trim_mag = '0;
  logic sec_tick, test_wave;
  logic [MIN_W-1:0] minute;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rate_trim_divider #(.PRE_W(PRE_W), .SUB_W(SUB_W), .SEC_PER_MIN(SPM), .MIN_W(MIN_W), .MAG_W(MAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .trim_mag(trim_mag), .trim_pos(trim_pos),
    .sec_tick(sec_tick), .minute(minute), .test_wave(test_wave));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(int s, int m, int mag, bit pos);
    if (s == 0 && m < 2 * mag) return pos ? NOM - STAGE : NOM + HALF;
    return NOM;
  endfunction

  function automatic string tag_for(bit first, int s, int m, int mag, bit pos, int dmag, bit dpos);
    if (first) return "R1";
    if (s == 0 && m < 2 * mag) return pos ? "R3" : "R4";
    if (mag != 0) return "R5";
    if (dmag != mag || dpos != pos) return "R7";
    return "R2";
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int s = 0, m = 0, lmag = 0, cyc = 0, n = 0, total = 0, clocks = 0, idle = 0;
    bit lpos = 1'b0, first = 1'b1, en_prev, prev_wave = 1'b0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check(sec_tick == 1'b0, "R1", sec_tick, 0);
    check(minute == '0, "R1", minute, 0);
    check(test_wave == 1'b0, "R1", test_wave, 0);
    rst_n = 1'b1;
    while (cyc < 12 && clocks < 190000) begin
      @(negedge clk);
      clocks++;
      en_prev = osc_en;
      total += int'(en_prev);
      n += int'(en_prev);
      if (clocks == 1) check(minute == '0 && sec_tick == 1'b0, "R1", minute, 0);
      check(test_wave == total[PRE_W-3], "R8", test_wave, total[PRE_W-3]);
      if (!en_prev) check(test_wave == prev_wave, "R8", test_wave, prev_wave);
      prev_wave = test_wave;
      if (sec_tick) begin
        check(en_prev, "R9", en_prev, 1);
        check(n == exp_period(s, m, lmag, lpos),
              tag_for(first, s, m, lmag, lpos, trim_mag, trim_pos), n, exp_period(s, m, lmag, lpos));
        first = 1'b0;
        n = 0;
        s++;
        if (s == SPM) begin
          s = 0;
          m++;
          if (m == NMIN) begin
            m = 0;
            lmag = trim_mag;
            lpos = trim_pos;
            cyc++;
          end
        end
        check(minute == MIN_W'(m), "R6", minute, m);
        if (s == 0 && m == 10) begin
          case (cyc)
            0: begin trim_mag = 5'd3;  trim_pos = 1'b1; end
            1: begin trim_mag = 5'd5;  trim_pos = 1'b0; end
            2: begin trim_mag = 5'd31; trim_pos = 1'b1; end
            3: begin trim_mag = 5'd31; trim_pos = 1'b0; end
            4: begin trim_mag = 5'd0;  trim_pos = 1'b1; end
            default: begin trim_mag = MAG_W'($urandom % 32); trim_pos = 1'($urandom % 2); end
          endcase
        end
        if (s == 0 && m == 40 && (cyc == 1 || cyc >= 6)) begin
          trim_mag = (cyc == 1) ? 5'd7 : MAG_W'($urandom % 32);
          trim_pos = (cyc == 1) ? 1'b0 : 1'($urandom % 2);
        end
        if (cyc == 2 && m == 5 && s == 1) idle = 40;
      end else begin
        check(minute == MIN_W'(m), "R6", minute, m);
      end
      if (idle > 0) begin
        osc_en = 1'b0;
        idle--;
      end else begin
        osc_en = ($urandom % 4) != 0;
      end
    end
    check(cyc == 12, "R6", cyc, 12);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule